// File: doc/BRIEF.md
# Two-Wire Banked Register Access Slave

This block is a slave on a two-wire serial bus. It lets a host reach 16-bit configuration registers through 8-bit register addresses. SCL and SDA are sampled in the system clock domain. Each line passes through a two-flop synchronizer and a glitch filter. Edge detection then recognises start, repeated start, stop and the data bits. SDA is driven open-drain: `sda_oe_o` high pulls the line low.

A write carries a register address and then whole 16-bit words, high byte first. Each completed word gives a one-cycle strobe on the register-file side, carrying address, data and bank. Reads return words high byte first from `rd_data_i`. Writes and reads both advance the register pointer after each word. Hosts that can only move one byte at a time use the byte port at address 0x7F to finish or fetch the low half. The bank select register at 0x01 lives inside the block, so it can be reached from either bank.

Top module: `twr_bank_slave`

## Requirements
- R1: The 7-bit device address is 0x48 (address byte 0x90/0x91) when `addr_sel_i` is 0, and 0x5C (0xB8/0xB9) when it is 1. Bit 0 of the address byte is the direction: 0 for write, 1 for read. On a mismatch the slave leaves SDA released during the acknowledge bit, and it ignores all traffic until the next start.
- R2: A write sends the register address, then the data high byte, then the low byte. When the low byte completes, `wr_en_o` pulses for one cycle with `wr_addr_o`, `wr_data_o` and `wr_bank_o`.
- R3: No strobe is issued before both bytes of a word arrive. A lone byte followed by a stop leaves every register unchanged.
- R4: After each 16-bit word written or read, the register pointer increments. Continued bytes address the next register.
- R5: The slave pulls SDA low during the acknowledge clock of each matched address byte, each register address byte and each written data byte. It changes SDA only while SCL is low.
- R6: A read is a write-mode address and register address, then a repeated start and the read-mode address. Data comes out high byte first. A master ACK continues the read; a master NACK ends it with SDA released.
- R7: Address 0x7F is a byte port. A byte written there commits {held high byte, that byte} to the last register addressed by a normal write. A read there returns the low byte of that register. Address 0x7F is never forwarded as a strobe.
- R8: Register 0x01 is the bank select and resets to 0x0004. Its bit 0 picks the bank: 0 for the sensor bank (0x0004), 1 for the processor bank (0x0001). It is held inside the block, reads back from either bank, and is not forwarded. Register 0x00 is always forwarded with bank 0.
- R9: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. A stop in the middle of a byte discards that byte.
- R10: Pulses on SCL or SDA shorter than FILT_LEN system clocks (3 by default) have no effect on the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line from the pad |
| sda_i | input | 1 | Serial data line from the pad |
| sda_oe_o | output | 1 | Pull SDA low when high |
| addr_sel_i | input | 1 | Device address select |
| wr_en_o | output | 1 | One-cycle register write strobe |
| wr_addr_o | output | 8 | Register address of the write |
| wr_data_o | output | 16 | Register data of the write |
| wr_bank_o | output | 1 | Bank of the write (0 sensor, 1 processor) |
| rd_addr_o | output | 8 | Register address being read |
| rd_bank_o | output | 1 | Bank being read |
| rd_data_i | input | 16 | Read data from the register file |

## Verification
If the bit counter or the state is wrong, the effect shows within one byte: a missing or misplaced acknowledge, or a data byte shifted by one bit. If the half-word phase or the pointer is wrong, the strobe lands on the wrong address, a strobe is missing after the second byte, or a read returns the other half of the word, all by the end of the next word. A held byte or byte-port target that was lost shows at the first 0x7F access. A bank select that was lost shows in the bank of the next strobe.

// File: rtl/twr_pkg.sv
package twr_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;

  localparam logic [BYTE_W-1:0] BYTE_PORT = 8'h7F;
  localparam logic [BYTE_W-1:0] BANK_REG  = 8'h01;
  localparam logic [6:0]        DEV_LO    = 7'h48;
  localparam logic [6:0]        DEV_HI    = 7'h5C;
  localparam logic [WORD_W-1:0] BANK_RST  = 16'h0004;

  typedef enum logic [3:0] {
    ST_IDLE, ST_DEV, ST_DEV_ACK, ST_REG, ST_REG_ACK,
    ST_WR, ST_WR_ACK, ST_RD, ST_RD_ACK
  } twr_state_e;
endpackage

// File: rtl/twr_line_filter.sv
module twr_line_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);
  localparam int CW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b11;
      cnt_q  <= '0;
      line_o <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], line_i};
      if (sync_q[1] == line_o) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(FILT_LEN - 1)) begin
        line_o <= sync_q[1];
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  AST_FILT_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(line_o) |-> (line_o == $past(sync_q[1]))); // R10
endmodule

// File: rtl/twr_bus_events.sv
module twr_bus_events (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/twr_bank_slave.sv
module twr_bank_slave
  import twr_pkg::*;
#(
  parameter int FILT_LEN = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic              addr_sel_i,
  output logic              wr_en_o,
  output logic [BYTE_W-1:0] wr_addr_o,
  output logic [WORD_W-1:0] wr_data_o,
  output logic              wr_bank_o,
  output logic [BYTE_W-1:0] rd_addr_o,
  output logic              rd_bank_o,
  input  logic [WORD_W-1:0] rd_data_i
);
  logic [1:0] raw_w, filt_w;
  assign raw_w = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_filt
    twr_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .line_i(raw_w[g]),
      .line_o(filt_w[g])
    );
  end

  logic scl_f, sda_f;
  assign scl_f = filt_w[0];
  assign sda_f = filt_w[1];

  logic scl_rise, scl_fall, bus_start, bus_stop;
  twr_bus_events u_evt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (scl_f),
    .sda_i     (sda_f),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (bus_start),
    .stop_o    (bus_stop)
  );

  twr_state_e        state_q;
  logic [BYTE_W-1:0] shreg_q, ptr_q, tgt_q, hold_q;
  logic [3:0]        bitcnt_q;
  logic              rw_q, half_q, mack_q, oe_q;
  logic [WORD_W-1:0] bank_sel_q;

  logic [BYTE_W-1:0] rd_sel, tx_byte, ptr_inc, commit_addr;
  logic [WORD_W-1:0] rd_word, commit_data;
  logic              dev_match, byte_end, commit_v;

  always_comb begin
    rd_sel      = (ptr_q == BYTE_PORT) ? tgt_q : ptr_q;
    rd_word     = (rd_sel == BANK_REG) ? bank_sel_q : rd_data_i;
    tx_byte     = (ptr_q == BYTE_PORT || half_q) ? rd_word[7:0] : rd_word[15:8];
    ptr_inc     = ptr_q + 1'b1;
    dev_match   = shreg_q[7:1] == (addr_sel_i ? DEV_HI : DEV_LO);
    byte_end    = scl_fall && (bitcnt_q == 4'd8);
    commit_v    = (state_q == ST_WR) && byte_end && (ptr_q == BYTE_PORT || half_q);
    commit_addr = (ptr_q == BYTE_PORT) ? tgt_q : ptr_q;
    commit_data = {hold_q, shreg_q};
  end

  assign rd_addr_o = rd_sel;
  assign rd_bank_o = (rd_sel == '0) ? 1'b0 : bank_sel_q[0];
  assign sda_oe_o  = oe_q;

  // protocol engine
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      shreg_q  <= '0;
      ptr_q    <= '0;
      tgt_q    <= '0;
      hold_q   <= '0;
      bitcnt_q <= '0;
      rw_q     <= 1'b0;
      half_q   <= 1'b0;
      mack_q   <= 1'b0;
      oe_q     <= 1'b0;
    end else if (bus_start) begin
      state_q  <= ST_DEV;
      bitcnt_q <= '0;
      half_q   <= 1'b0;
      oe_q     <= 1'b0;
    end else if (bus_stop) begin
      state_q <= ST_IDLE;
      oe_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_DEV, ST_REG, ST_WR: begin
          if (scl_rise) begin
            shreg_q  <= {shreg_q[6:0], sda_f};
            bitcnt_q <= bitcnt_q + 1'b1;
          end
          if (byte_end) begin
            bitcnt_q <= '0;
            if (state_q == ST_DEV) begin
              if (dev_match) begin
                rw_q    <= shreg_q[0];
                oe_q    <= 1'b1;
                state_q <= ST_DEV_ACK;
              end else begin
                state_q <= ST_IDLE;
              end
            end else if (state_q == ST_REG) begin
              ptr_q   <= shreg_q;
              if (shreg_q != BYTE_PORT) tgt_q <= shreg_q;
              half_q  <= 1'b0;
              oe_q    <= 1'b1;
              state_q <= ST_REG_ACK;
            end else begin
              oe_q    <= 1'b1;
              state_q <= ST_WR_ACK;
              if (ptr_q != BYTE_PORT) begin
                if (!half_q) begin
                  hold_q <= shreg_q;
                  half_q <= 1'b1;
                end else begin
                  half_q <= 1'b0;
                  ptr_q  <= ptr_inc;
                  if (ptr_inc != BYTE_PORT) tgt_q <= ptr_inc;
                end
              end
            end
          end
        end
        ST_DEV_ACK: if (scl_fall) begin
          if (rw_q) begin
            shreg_q  <= tx_byte;
            oe_q     <= ~tx_byte[7];
            bitcnt_q <= '0;
            state_q  <= ST_RD;
          end else begin
            oe_q    <= 1'b0;
            state_q <= ST_REG;
          end
        end
        ST_REG_ACK, ST_WR_ACK: if (scl_fall) begin
          oe_q    <= 1'b0;
          state_q <= ST_WR;
        end
        ST_RD: begin
          if (scl_rise) bitcnt_q <= bitcnt_q + 1'b1;
          if (byte_end) begin
            oe_q     <= 1'b0;
            bitcnt_q <= '0;
            state_q  <= ST_RD_ACK;
            if (ptr_q != BYTE_PORT) begin
              if (half_q) begin
                half_q <= 1'b0;
                ptr_q  <= ptr_inc;
                if (ptr_inc != BYTE_PORT) tgt_q <= ptr_inc;
              end else begin
                half_q <= 1'b1;
              end
            end
          end else if (scl_fall) begin
            shreg_q <= {shreg_q[6:0], 1'b0};
            oe_q    <= ~shreg_q[6];
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) mack_q <= ~sda_f;
          if (scl_fall) begin
            if (mack_q) begin
              shreg_q  <= tx_byte;
              oe_q     <= ~tx_byte[7];
              bitcnt_q <= '0;
              state_q  <= ST_RD;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // register-file side
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_sel_q <= BANK_RST;
      wr_en_o    <= 1'b0;
      wr_addr_o  <= '0;
      wr_data_o  <= '0;
      wr_bank_o  <= 1'b0;
    end else begin
      wr_en_o <= 1'b0;
      if (commit_v) begin
        if (commit_addr == BANK_REG) begin
          bank_sel_q <= commit_data;
        end else begin
          wr_en_o   <= 1'b1;
          wr_addr_o <= commit_addr;
          wr_data_o <= commit_data;
          wr_bank_o <= (commit_addr == '0) ? 1'b0 : bank_sel_q[0];
        end
      end
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> !sda_oe_o); // R1
  AST_DRIVE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_f); // R5
  AST_STROBE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> !wr_en_o); // R3
  AST_NO_FWD_PORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (wr_addr_o != BYTE_PORT && wr_addr_o != BANK_REG)); // R7
  AST_ZERO_CORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && wr_addr_o == '0) |-> !wr_bank_o); // R8
endmodule

// File: tb/twr_bank_slave_test.sv
module twr_bank_slave_test;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, addr_sel = 1'b1;
  logic sda_oe, wr_en, wr_bank, rd_bank, sda_line;
  logic [7:0]  wr_addr, rd_addr;
  logic [15:0] wr_data, rd_data;
  logic [15:0] rf [0:511];

  int total = 0, bad = 0, wcnt = 0;
  logic [7:0]  wa [0:15];
  logic [15:0] wd [0:15];
  logic        wb [0:15];

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;
  assign rd_data  = rf[{rd_bank, rd_addr}];

  twr_bank_slave uut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .addr_sel_i(addr_sel),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data), .wr_bank_o(wr_bank),
    .rd_addr_o(rd_addr), .rd_bank_o(rd_bank), .rd_data_i(rd_data)
  );

  always @(negedge clk) begin
    if (wr_en) begin
      if (wcnt < 16) begin
        wa[wcnt] = wr_addr; wd[wcnt] = wr_data; wb[wcnt] = wr_bank;
      end
      rf[{wr_bank, wr_addr}] = wr_data;
      wcnt++;
    end
  end

  localparam logic [23:0] VEC [0:5] = '{
    {8'h09, 16'h0284}, {8'h10, 16'hFFFF}, {8'h3C, 16'h0000},
    {8'hA5, 16'h5AA5}, {8'hFE, 16'h8001}, {8'h40, 16'h1234}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] dev(input logic rd);
    return {(addr_sel ? 7'h5C : 7'h48), rd};
  endfunction

  // gl: 1 = short SCL pulse in low phase, 2 = short SDA dip in high phase
  task automatic bus_bit(input logic b, input int gl, output logic s);
    sda_m = b; tick(Q/2);
    if (gl == 1) begin scl_m = 1'b1; tick(2); scl_m = 1'b0; end
    tick(Q/2);
    scl_m = 1'b1; tick(Q/2);
    if (gl == 2 && b) begin sda_m = 1'b0; tick(2); sda_m = 1'b1; end
    tick(Q/2);
    s = sda_line; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] v, input int gl, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bus_bit(v[i], gl, s);
    bus_bit(1'b1, 0, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] v);
    logic s;
    for (int i = 7; i >= 0; i--) begin bus_bit(1'b1, 0, s); v[i] = s; end
    bus_bit(~mack, 0, s);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic write_reg(input logic [7:0] r, input logic [15:0] d, output logic ok);
    logic a0, a1, a2, a3;
    bus_start();
    send_byte(dev(1'b0), 0, a0); send_byte(r, 0, a1);
    send_byte(d[15:8], 0, a2);   send_byte(d[7:0], 0, a3);
    bus_stop();
    ok = a0 & a1 & a2 & a3;
  endtask

  task automatic read_reg(input logic [7:0] r, output logic [15:0] w, output logic ok);
    logic a0, a1, a2;
    bus_start();
    send_byte(dev(1'b0), 0, a0); send_byte(r, 0, a1);
    bus_start();
    send_byte(dev(1'b1), 0, a2);
    recv_byte(1'b1, w[15:8]); recv_byte(1'b0, w[7:0]);
    tick(Q);
    chk("R6 released after nack", {31'd0, sda_oe}, 32'd0);
    bus_stop();
    ok = a0 & a1 & a2;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    logic ok, a0, a1, a2, s;
    logic [15:0] w;
    logic [7:0]  b0, b1, b2, b3;
    for (int i = 0; i < 512; i++) rf[i] = '0;
    tick(5); rst_n = 1'b1; tick(5);

    chk("reset sda_oe", {31'd0, sda_oe}, 32'd0);
    chk("R3 reset no strobe", {31'd0, wr_en}, 32'd0);
    chk("R8 reset bank", {31'd0, rd_bank}, 32'd0);

    // table walk: write a word, then read it back (R2 R5 R6)
    for (int v = 0; v < 6; v++) begin
      wcnt = 0;
      write_reg(VEC[v][23:16], VEC[v][15:0], ok);
      chk("R5 write acks", {31'd0, ok}, 32'd1);
      chk("R2 strobe count", wcnt, 1);
      chk("R2 strobe addr", {24'd0, wa[0]}, {24'd0, VEC[v][23:16]});
      chk("R2 strobe data", {16'd0, wd[0]}, {16'd0, VEC[v][15:0]});
      chk("R2 strobe bank", {31'd0, wb[0]}, 32'd0);
      read_reg(VEC[v][23:16], w, ok);
      chk("R6 read word", {16'd0, w}, {16'd0, VEC[v][15:0]});
      chk("R6 read acks", {31'd0, ok}, 32'd1);
    end

    // R1: mismatched device address
    wcnt = 0;
    bus_start();
    send_byte(8'h90, 0, a0); send_byte(8'h20, 0, a1);
    send_byte(8'h11, 0, a2); send_byte(8'h22, 0, ok);
    bus_stop();
    chk("R1 nack mismatch", {31'd0, a0}, 32'd0);
    chk("R1 ignored after mismatch", {31'd0, a1 | a2 | ok}, 32'd0);
    chk("R1 no strobe on mismatch", wcnt, 0);
    addr_sel = 1'b0;
    write_reg(8'h21, 16'hBEEF, ok);
    chk("R1 low select acks", {31'd0, ok}, 32'd1);
    chk("R1 low select strobe", {16'd0, wd[0]}, 32'h0000BEEF);
    addr_sel = 1'b1;

    // R3: lone byte
    wcnt = 0;
    bus_start();
    send_byte(dev(1'b0), 0, a0); send_byte(8'h30, 0, a1); send_byte(8'hAA, 0, a2);
    bus_stop();
    chk("R3 lone byte no strobe", wcnt, 0);
    read_reg(8'h30, w, ok);
    chk("R3 register unchanged", {16'd0, w}, 32'd0);

    // R4: auto-increment on write and read
    wcnt = 0;
    bus_start();
    send_byte(dev(1'b0), 0, a0); send_byte(8'h50, 0, a0);
    send_byte(8'h11, 0, a0); send_byte(8'h22, 0, a0);
    send_byte(8'h33, 0, a0); send_byte(8'h44, 0, a0);
    bus_stop();
    chk("R4 two strobes", wcnt, 2);
    chk("R4 first addr", {24'd0, wa[0]}, 32'h50);
    chk("R4 first data", {16'd0, wd[0]}, 32'h1122);
    chk("R4 second addr", {24'd0, wa[1]}, 32'h51);
    chk("R4 second data", {16'd0, wd[1]}, 32'h3344);
    bus_start();
    send_byte(dev(1'b0), 0, a0); send_byte(8'h50, 0, a0);
    bus_start(); send_byte(dev(1'b1), 0, a0);
    recv_byte(1'b1, b0); recv_byte(1'b1, b1); recv_byte(1'b1, b2); recv_byte(1'b0, b3);
    bus_stop();
    chk("R4 multi read", {b0, b1, b2, b3}, 32'h11223344);

    // R7: byte port
    wcnt = 0;
    bus_start();
    send_byte(dev(1'b0), 0, a0); send_byte(8'h20, 0, a0); send_byte(8'hC3, 0, a0);
    bus_stop();
    chk("R7 high half alone", wcnt, 0);
    bus_start();
    send_byte(dev(1'b0), 0, a0); send_byte(8'h7F, 0, a0); send_byte(8'h5A, 0, a1);
    bus_stop();
    chk("R7 port ack", {31'd0, a1}, 32'd1);
    chk("R7 port strobe count", wcnt, 1);
    chk("R7 port target", {24'd0, wa[0]}, 32'h20);
    chk("R7 port data", {16'd0, wd[0]}, 32'hC35A);
    bus_start();
    send_byte(dev(1'b0), 0, a0); send_byte(8'h7F, 0, a0);
    bus_start(); send_byte(dev(1'b1), 0, a0);
    recv_byte(1'b0, b0);
    bus_stop();
    chk("R7 port read low", {24'd0, b0}, 32'h5A);

    // R8: bank select
    read_reg(8'h01, w, ok);
    chk("R8 bank reset value", {16'd0, w}, 32'h0004);
    wcnt = 0;
    write_reg(8'h01, 16'h0001, ok);
    chk("R8 bank reg not forwarded", wcnt, 0);
    write_reg(8'h10, 16'h00AB, ok);
    chk("R8 processor bank strobe", {31'd0, wb[0]}, 32'd1);
    read_reg(8'h01, w, ok);
    chk("R8 bank readback", {16'd0, w}, 32'h0001);
    write_reg(8'h00, 16'h0077, ok);
    chk("R8 reg zero bank", {31'd0, wb[1]}, 32'd0);
    read_reg(8'h10, w, ok);
    chk("R8 read processor bank", {16'd0, w}, 32'h00AB);
    write_reg(8'h01, 16'h0004, ok);
    read_reg(8'h10, w, ok);
    chk("R8 read sensor bank", {16'd0, w}, 32'hFFFF);

    // R9: stop in mid byte
    wcnt = 0;
    bus_start();
    send_byte(dev(1'b0), 0, a0); send_byte(8'h60, 0, a0); send_byte(8'h12, 0, a0);
    bus_bit(1'b0, 0, s); bus_bit(1'b1, 0, s); bus_bit(1'b1, 0, s); bus_bit(1'b0, 0, s);
    bus_stop();
    chk("R9 partial byte dropped", wcnt, 0);
    write_reg(8'h61, 16'h0F0F, ok);
    chk("R9 next transfer clean", {16'd0, wd[0]}, 32'h0F0F);

    // R10: short pulses on both lines
    wcnt = 0;
    bus_start();
    send_byte(dev(1'b0), 1, a0); send_byte(8'h70, 2, a1);
    send_byte(8'hA6, 1, a2); send_byte(8'h5F, 2, ok);
    bus_stop();
    chk("R10 glitch acks", {31'd0, a0 & a1 & a2 & ok}, 32'd1);
    chk("R10 glitch strobe", wcnt, 1);
    chk("R10 glitch addr", {24'd0, wa[0]}, 32'h70);
    chk("R10 glitch data", {16'd0, wd[0]}, 32'hA65F);

    finish_run();
  end
endmodule